// File: doc/BRIEF.md
# 100BASE-TX Transmit Code-Group Framer

This block sits between the MAC-facing transmit nibble interface and the scrambler of a 100 Mb/s twisted-pair transmitter. On every 25 MHz transmit clock it samples a data nibble, a frame enable and an error flag. It then emits one registered 5-bit code group, ready for scrambling and serialization.

Between frames it sends the all-ones idle group. When a frame starts, the first two nibbles are preamble, and the block replaces that octet with the start-of-stream pair. Frame nibbles go through the 4B5B data mapping. A flagged nibble becomes the halt group. When the enable falls, the end-of-stream pair is appended.

A lock input from the transmit clock generator silences the output entirely until the generator is stable. A bypass control lets a raw 5-bit symbol pass straight through, using the error flag as the fifth bit. All code groups in this project are written most significant bit first. `codeOut[4]` is the bit that the serializer sends first.

Top module: `tx_symbol_framer`

## Requirements
- R1: After reset, `codeOut` is 00000 and `codeValid` is 0. Inputs sampled on a rising clock edge produce the matching code group at the outputs just after that same edge, which is one register stage of latency.
- R2: With the lock input high, the bypass low and no frame in progress, a sample with `txEn` low produces the idle group 11111.
- R3: `txErr` sampled high while `txEn` is low has no effect: the output stays 11111.
- R4: The first sample with `txEn` high after idle produces J (11000). The next sample produces K (10001). The nibbles and `txErr` of both of these samples are discarded.
- R5: Each later sample with `txEn` high and `txErr` low produces the 4B5B data group for `txData`: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: A data-phase sample with `txEn` and `txErr` both high produces the halt group 00100, whatever `txData` holds.
- R7: The first data-phase sample with `txEn` low produces T (01101). The next sample produces R (00111) whatever the inputs are. The sample after that is handled as idle, so a high `txEn` there starts a new frame with J.
- R8: If `txEn` is low in the sample that produces K, the frame still ends with T and then R on the following two samples.
- R9: While `pllLocked` is sampled low, `codeValid` is 0 and `codeOut` is 00000. Any frame in progress is abandoned, and framing restarts from idle.
- R10: While `bypassEnc` is sampled high (with lock high), `codeOut` equals {`txErr`, `txData`} and `codeValid` is 1, with no framing. Framing restarts from idle once bypass is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| txEn | input | 1 | Frame enable from the MAC |
| txErr | input | 1 | Transmit error flag; fifth raw bit in bypass |
| txData | input | 4 | Transmit nibble |
| pllLocked | input | 1 | Transmit clock generator lock indication |
| bypassEnc | input | 1 | Raw 5-bit symbol pass-through select |
| codeOut | output | 5 | Code group, bit 4 first on the line |
| codeValid | output | 1 | High when `codeOut` may be sent to the line |

## Verification
The first directed frame walks all sixteen nibble values, which separates a wrong table entry from a wrong framing step. A one-sample frame and a frame that restarts during R separate the short-frame path and the back-to-back path from the normal end of frame. Error flags are driven both inside and outside frames, which shows that the halt group depends on the enable. Random frames then mix in lock drops and bypass pulses at arbitrary points, which shows that both controls abandon a frame and return it cleanly to idle.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;

  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;

  localparam logic [SYM_W-1:0] CODE_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CODE_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CODE_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CODE_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CODE_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CODE_H    = 5'b00100;
  localparam logic [SYM_W-1:0] CODE_OFF  = '0;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEND_K = 3'd1,
    ST_DATA   = 3'd2,
    ST_SEND_T = 3'd3,
    ST_SEND_R = 3'd4
  } frameState_e;

  typedef enum logic [2:0] {
    KIND_IDLE = 3'd0,
    KIND_J    = 3'd1,
    KIND_K    = 3'd2,
    KIND_DATA = 3'd3,
    KIND_HALT = 3'd4,
    KIND_T    = 3'd5,
    KIND_R    = 3'd6
  } symKind_e;

  typedef struct packed {
    logic     lineOn;
    logic     rawPass;
    symKind_e kind;
  } symStrobe_t;

  function automatic logic [SYM_W-1:0] map4b5b(input logic [NIB_W-1:0] nib);
    logic [SYM_W-1:0] grp;
    unique case (nib)
      4'h0: grp = 5'b11110;
      4'h1: grp = 5'b01001;
      4'h2: grp = 5'b10100;
      4'h3: grp = 5'b10101;
      4'h4: grp = 5'b01010;
      4'h5: grp = 5'b01011;
      4'h6: grp = 5'b01110;
      4'h7: grp = 5'b01111;
      4'h8: grp = 5'b10010;
      4'h9: grp = 5'b10011;
      4'hA: grp = 5'b10110;
      4'hB: grp = 5'b10111;
      4'hC: grp = 5'b11010;
      4'hD: grp = 5'b11011;
      4'hE: grp = 5'b11100;
      default: grp = 5'b11101;
    endcase
    return grp;
  endfunction

endpackage

// File: rtl/tx_framer_ctrl.sv
module tx_framer_ctrl
  import tx_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       txErr,
  input  logic       pllLocked,
  input  logic       bypassEnc,
  output symStrobe_t strobe
);

  frameState_e state;
  frameState_e stateNxt;

  always_comb begin
    stateNxt       = state;
    strobe.lineOn  = pllLocked;
    strobe.rawPass = 1'b0;
    strobe.kind    = KIND_IDLE;
    if (!pllLocked) begin
      stateNxt = ST_IDLE;
    end else if (bypassEnc) begin
      strobe.rawPass = 1'b1;
      stateNxt       = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (txEn) begin
            strobe.kind = KIND_J;
            stateNxt    = ST_SEND_K;
          end
        end
        ST_SEND_K: begin
          strobe.kind = KIND_K;
          stateNxt    = txEn ? ST_DATA : ST_SEND_T;
        end
        ST_DATA: begin
          if (txEn) begin
            strobe.kind = txErr ? KIND_HALT : KIND_DATA;
          end else begin
            strobe.kind = KIND_T;
            stateNxt    = ST_SEND_R;
          end
        end
        ST_SEND_T: begin
          strobe.kind = KIND_T;
          stateNxt    = ST_SEND_R;
        end
        ST_SEND_R: begin
          strobe.kind = KIND_R;
          stateNxt    = ST_IDLE;
        end
        default: begin
          stateNxt = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // After J, the next framed sample must be K.
  assert_j_then_k_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && txEn && pllLocked && !bypassEnc) |=> (state == ST_SEND_K));

  // After K, the frame either carries data or closes with T (R8).
  assert_k_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND_K && pllLocked && !bypassEnc)
      |=> (state == ST_DATA || state == ST_SEND_T));

  // T is always followed by R.
  assert_t_then_r_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SEND_T || (state == ST_DATA && !txEn)) && pllLocked && !bypassEnc)
      |=> (state == ST_SEND_R));

  // Lock loss or bypass abandons the frame.
  assert_abandon_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!pllLocked || bypassEnc) |=> (state == ST_IDLE));

endmodule

// File: rtl/tx_framer_datapath.sv
module tx_framer_datapath
  import tx_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  symStrobe_t       strobe,
  input  logic [NIB_W-1:0] txData,
  input  logic             txErr,
  output logic [SYM_W-1:0] codeOut,
  output logic             codeValid
);

  logic [SYM_W-1:0] codeNxt;

  always_comb begin
    if (!strobe.lineOn) begin
      codeNxt = CODE_OFF;
    end else if (strobe.rawPass) begin
      codeNxt = {txErr, txData};
    end else begin
      unique case (strobe.kind)
        KIND_J:    codeNxt = CODE_J;
        KIND_K:    codeNxt = CODE_K;
        KIND_DATA: codeNxt = map4b5b(txData);
        KIND_HALT: codeNxt = CODE_H;
        KIND_T:    codeNxt = CODE_T;
        KIND_R:    codeNxt = CODE_R;
        default:   codeNxt = CODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeOut   <= CODE_OFF;
      codeValid <= 1'b0;
    end else begin
      codeOut   <= codeNxt;
      codeValid <= strobe.lineOn;
    end
  end

  assert_lock_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lineOn |=> (!codeValid && codeOut == CODE_OFF));

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lineOn && !strobe.rawPass && strobe.kind == KIND_IDLE)
      |=> (codeValid && codeOut == CODE_IDLE));

  assert_halt_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lineOn && !strobe.rawPass && strobe.kind == KIND_HALT)
      |=> (codeOut == CODE_H));

  assert_raw_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lineOn && strobe.rawPass)
      |=> (codeValid && codeOut == {$past(txErr), $past(txData)}));

endmodule

// File: rtl/tx_symbol_framer.sv
module tx_symbol_framer
  import tx_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             txErr,
  input  logic [NIB_W-1:0] txData,
  input  logic             pllLocked,
  input  logic             bypassEnc,
  output logic [SYM_W-1:0] codeOut,
  output logic             codeValid
);

  symStrobe_t strobe;

  tx_framer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEn      (txEn),
    .txErr     (txErr),
    .pllLocked (pllLocked),
    .bypassEnc (bypassEnc),
    .strobe    (strobe)
  );

  tx_framer_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .txData    (txData),
    .txErr     (txErr),
    .codeOut   (codeOut),
    .codeValid (codeValid)
  );

  // An idle-state error flag with the enable low never reaches the line (R3).
  assert_err_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pllLocked && !bypassEnc && !txEn && txErr && codeValid && codeOut == CODE_IDLE)
      |=> (codeOut != CODE_H));

endmodule

// File: tb/tb_tx_symbol_framer.sv
module tb_tx_symbol_framer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b0;
  logic       txErr = 1'b0;
  logic [3:0] txData = 4'h0;
  logic       pllLocked = 1'b0;
  logic       bypassEnc = 1'b0;
  logic [4:0] codeOut;
  logic       codeValid;

  int checks = 0;
  int failures = 0;
  int mState = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_symbol_framer dut (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txErr(txErr), .txData(txData),
    .pllLocked(pllLocked), .bypassEnc(bypassEnc),
    .codeOut(codeOut), .codeValid(codeValid)
  );

  function automatic logic [4:0] refMap(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  // Reference model from the requirements; mState: 0 idle, 1 K next, 2 data, 3 T next, 4 R next.
  task automatic refStep(input logic en, er, input logic [3:0] d, input logic lk, bp,
                         output logic [4:0] exCode, output logic exValid, output string tag);
    if (!lk) begin
      exCode = 5'b00000; exValid = 1'b0; mState = 0; tag = "R9";
    end else if (bp) begin
      exCode = {er, d}; exValid = 1'b1; mState = 0; tag = "R10";
    end else begin
      exValid = 1'b1;
      case (mState)
        0: if (en) begin exCode = 5'b11000; mState = 1; tag = "R4"; end
           else begin exCode = 5'b11111; tag = er ? "R3" : "R2"; end
        1: begin exCode = 5'b10001; tag = en ? "R4" : "R8"; mState = en ? 2 : 3; end
        2: if (en) begin
             if (er) begin exCode = 5'b00100; tag = "R6"; end
             else begin exCode = refMap(d); tag = "R5"; end
           end else begin exCode = 5'b01101; mState = 4; tag = "R7"; end
        3: begin exCode = 5'b01101; mState = 4; tag = "R8"; end
        default: begin exCode = 5'b00111; mState = 0; tag = "R7"; end
      endcase
    end
  endtask

  task automatic step(input logic en, er, input logic [3:0] d, input logic lk, bp);
    logic [4:0] exCode;
    logic exValid;
    string tag;
    @(negedge clk);
    txEn = en; txErr = er; txData = d; pllLocked = lk; bypassEnc = bp;
    refStep(en, er, d, lk, bp, exCode, exValid, tag);
    @(posedge clk);
    #1;
    checks++;
    if (codeOut !== exCode || codeValid !== exValid) begin
      failures++;
      $display("FAIL %s: got code=%b valid=%b, expected code=%b valid=%b",
               tag, codeOut, codeValid, exCode, exValid);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic cur;
    void'($urandom(32'd7321));
    #35;
    // R1: reset values before any clock edge after reset
    checks++;
    if (codeOut !== 5'b00000 || codeValid !== 1'b0) begin
      failures++;
      $display("FAIL R1: got code=%b valid=%b, expected code=00000 valid=0", codeOut, codeValid);
    end
    @(negedge clk);
    rstN = 1'b1;
    // R2 idle, R3 error flag outside a frame
    step(0, 0, 4'h3, 1, 0);
    step(0, 0, 4'h0, 1, 0);
    step(0, 1, 4'h5, 1, 0);
    step(0, 1, 4'hF, 1, 0);
    // R4/R5: frame carrying all sixteen nibbles, with an error flag during the preamble
    step(1, 1, 4'h5, 1, 0);
    step(1, 0, 4'h5, 1, 0);
    for (int i = 0; i < 16; i++) step(1, 0, 4'(i), 1, 0);
    // R6 halt groups
    step(1, 1, 4'hA, 1, 0);
    step(1, 1, 4'h0, 1, 0);
    step(1, 0, 4'h9, 1, 0);
    // R7 end of stream, then a back-to-back start during R
    step(0, 0, 4'h0, 1, 0);
    step(1, 0, 4'h0, 1, 0);
    step(1, 0, 4'h0, 1, 0);
    step(1, 0, 4'h0, 1, 0);
    step(1, 0, 4'h7, 1, 0);
    step(0, 0, 4'h0, 1, 0);
    step(0, 0, 4'h0, 1, 0);
    step(0, 0, 4'h0, 1, 0);
    // R8 one-sample frame
    step(1, 0, 4'h5, 1, 0);
    step(0, 0, 4'h5, 1, 0);
    step(0, 1, 4'h5, 1, 0);
    step(0, 0, 4'h5, 1, 0);
    step(0, 0, 4'h5, 1, 0);
    // R9 lock drop in mid-frame and recovery
    step(1, 0, 4'h5, 1, 0);
    step(1, 0, 4'h5, 1, 0);
    step(1, 0, 4'h2, 1, 0);
    step(1, 0, 4'h2, 0, 0);
    step(0, 0, 4'h2, 0, 0);
    step(0, 0, 4'h2, 1, 0);
    step(1, 0, 4'h2, 1, 0);
    step(1, 0, 4'h2, 1, 0);
    // R10 bypass mid-frame, raw values, release
    step(1, 0, 4'hC, 1, 1);
    step(1, 1, 4'h3, 1, 1);
    step(0, 1, 4'h0, 1, 1);
    step(0, 0, 4'hF, 1, 1);
    step(0, 0, 4'h0, 1, 0);
    step(1, 0, 4'h0, 1, 0);
    step(1, 0, 4'h0, 1, 0);
    step(0, 0, 4'h0, 1, 0);
    step(0, 0, 4'h0, 1, 0);
    // random frames mixed with lock drops and bypass pulses
    cur = 1'b0;
    for (int n = 0; n < 5000; n++) begin
      if (cur) cur = ($urandom_range(0, 99) >= 12);
      else     cur = ($urandom_range(0, 99) < 20);
      step(cur, ($urandom_range(0, 99) < 6), 4'($urandom_range(0, 15)),
           ($urandom_range(0, 99) >= 2), ($urandom_range(0, 99) < 3));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule